// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from memory: first an entry of the top-level table, which is chosen by the upper ten address bits, and then an entry of the leaf table, which is chosen by the next ten bits. The top-level table is located by a per-mode base register that holds a page frame number. The user mode and the supervisor mode each have their own base and their own translation enable. Both levels are checked for validity and for write protection, and each level uses its own bit positions for these flags. A failed walk returns one of three fault outcomes.

A translation that succeeds returns the physical address and the cache-inhibit flag of the page. On a successful access the walker also updates the leaf entry in memory to record the access, and on a write to record the modification. A client offers one request at a time with a valid/ready handshake. The result comes back with a one-cycle done strobe. The walker issues word reads through a request/response port and issues word writes through a separate write port.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to address {base, va[31:22], 2'b00}. Here base is the 20-bit frame of super_base_i when req_super_i is 1, and of user_base_i otherwise. The read address stays stable while the read request is stalled.
- R2: The second read goes to address {top_entry[31:12], va[21:12], 2'b00}.
- R3: If bit 1 of the top-level entry is 0, the walk ends with fault_o = 2'b01 (table fault), and no second read is made.
- R4: If the top-level entry is valid, has bit 2 (read-only) set, and the request is a write, the walk ends with fault_o = 2'b11 (protection fault), and no second read is made. A read through the same entry proceeds.
- R5: If bit 0 of the leaf entry is 0, the walk ends with fault_o = 2'b10 (page fault).
- R6: If the leaf entry is valid, has bit 2 (read-only) set, and the request is a write, the walk ends with fault_o = 2'b11.
- R7: On success fault_o = 2'b00, pa_o = {leaf[31:12], va[11:0]}, and cache_inh_o = leaf bit 6.
- R8: On success the leaf entry is written back to its own address with bit 3 (referenced) set, and also with bit 4 (modified) set if the request is a write. No write is made when those bits are already set or when the walk faults.
- R9: When translation is off for the request's mode, done_o rises one cycle after acceptance with pa_o = va, fault_o = 0, and no memory access. On any fault, pa_o = 0 and cache_inh_o = 0.
- R10: req_ready_o is high only when the walker is idle, and it is high after reset. done_o is a single-cycle pulse. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 32 | Virtual address |
| req_super_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_write_i | input | 1 | Request is a write |
| user_base_i | input | 20 | User top-level table frame |
| super_base_i | input | 20 | Supervisor top-level table frame |
| user_en_i | input | 1 | User translation enable |
| super_en_i | input | 1 | Supervisor translation enable |
| mem_rd_valid_o | output | 1 | Read request |
| mem_rd_addr_o | output | 32 | Read byte address |
| mem_rd_ready_i | input | 1 | Read request taken |
| mem_rd_rvalid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 32 | Read data |
| mem_wr_valid_o | output | 1 | Write-back request |
| mem_wr_addr_o | output | 32 | Write-back byte address |
| mem_wr_data_o | output | 32 | Write-back data |
| mem_wr_ready_i | input | 1 | Write-back taken |
| done_o | output | 1 | Result strobe |
| pa_o | output | 32 | Physical address |
| cache_inh_o | output | 1 | Page is not cacheable |
| fault_o | output | 2 | 00 none, 01 table, 10 page, 11 protection |

## Verification
The bench sweeps every combination of mode, direction, top-level valid and read-only bits, and leaf valid, read-only, referenced, modified and cache-inhibit bits. The read port stalls on alternate cycles throughout the sweep.

Three groups of errors are targeted:
- Protection checked at only one level. Such a design would translate a write through a read-only segment, or would make a leaf read after the segment check has already failed. Counting reads per walk exposes this.
- A swapped valid bit position. Such a design would report a table fault where a page fault is due, or the reverse.
- A faulty write-back. A design that always writes back, forgets the modified bit on writes, or writes after a fault leaves the wrong word in memory or shows the wrong write count.

Pass-through is checked for its one-cycle latency and for making no reads.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  parameter int unsigned OFF_W = 12;  // page offset bits
  parameter int unsigned ENT_B = 2;   // log2 entry bytes
  localparam int unsigned IDX_W   = OFF_W - ENT_B;
  localparam int unsigned ADDR_W  = OFF_W + 2 * IDX_W;
  localparam int unsigned FRAME_W = ADDR_W - OFF_W;

  localparam int unsigned SEG_V_BIT  = 1;
  localparam int unsigned SEG_RO_BIT = 2;
  localparam int unsigned PG_V_BIT   = 0;
  localparam int unsigned PG_RO_BIT  = 2;
  localparam int unsigned PG_REF_BIT = 3;
  localparam int unsigned PG_MOD_BIT = 4;
  localparam int unsigned PG_CI_BIT  = 6;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_TABLE = 2'b01,
    FLT_PAGE  = 2'b10,
    FLT_PROT  = 2'b11
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG_REQ, ST_SEG_WAIT, ST_PG_REQ, ST_PG_WAIT, ST_WB, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter bit IS_LEAF = 1'b0
) (
  input  logic [ADDR_W-1:0]  entry_i,
  input  logic               write_i,
  output fault_e             fault_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               ci_o,
  output logic [ADDR_W-1:0]  upd_o,
  output logic               wb_o
);
  assign frame_o = entry_i[ADDR_W-1:OFF_W];

  generate
    if (IS_LEAF) begin : g_leaf
      logic [ADDR_W-1:0] set_mask;
      always_comb begin
        set_mask = '0;
        set_mask[PG_REF_BIT] = 1'b1;
        set_mask[PG_MOD_BIT] = write_i;
      end
      always_comb begin
        if (!entry_i[PG_V_BIT])                   fault_o = FLT_PAGE;
        else if (entry_i[PG_RO_BIT] && write_i)   fault_o = FLT_PROT;
        else                                      fault_o = FLT_NONE;
      end
      assign ci_o  = entry_i[PG_CI_BIT];
      assign upd_o = entry_i | set_mask;
      assign wb_o  = (fault_o == FLT_NONE) && (upd_o != entry_i);
    end else begin : g_seg
      always_comb begin
        if (!entry_i[SEG_V_BIT])                  fault_o = FLT_TABLE;
        else if (entry_i[SEG_RO_BIT] && write_i)  fault_o = FLT_PROT;
        else                                      fault_o = FLT_NONE;
      end
      assign ci_o  = 1'b0;
      assign upd_o = entry_i;
      assign wb_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_va_i,
  input  logic               req_super_i,
  input  logic               req_write_i,
  input  logic [FRAME_W-1:0] user_base_i,
  input  logic [FRAME_W-1:0] super_base_i,
  input  logic               user_en_i,
  input  logic               super_en_i,
  output logic               mem_rd_valid_o,
  output logic [ADDR_W-1:0]  mem_rd_addr_o,
  input  logic               mem_rd_ready_i,
  input  logic               mem_rd_rvalid_i,
  output logic               mem_wr_valid_o,
  output logic [ADDR_W-1:0]  mem_wr_addr_o,
  output logic [ADDR_W-1:0]  mem_wr_data_o,
  input  logic               mem_wr_ready_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  pa_o,
  output logic               cache_inh_o,
  output logic [1:0]         fault_o,
  output logic               write_o,
  input  fault_e             seg_fault_i,
  input  logic [FRAME_W-1:0] seg_frame_i,
  input  fault_e             pg_fault_i,
  input  logic [FRAME_W-1:0] pg_frame_i,
  input  logic               pg_ci_i,
  input  logic [ADDR_W-1:0]  pg_upd_i,
  input  logic               pg_wb_i
);
  walk_st_e           st_q;
  logic [ADDR_W-1:0]  va_q, addr_q, pa_q, wb_q;
  logic               wr_q, ci_q;
  fault_e             flt_q;

  logic               xl_en;
  logic [FRAME_W-1:0] base_sel;

  assign xl_en    = req_super_i ? super_en_i : user_en_i;
  assign base_sel = req_super_i ? super_base_i : user_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      pa_q   <= '0;
      wb_q   <= '0;
      wr_q   <= 1'b0;
      ci_q   <= 1'b0;
      flt_q  <= FLT_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          wr_q  <= req_write_i;
          flt_q <= FLT_NONE;
          ci_q  <= 1'b0;
          if (!xl_en) begin
            pa_q <= req_va_i;
            st_q <= ST_DONE;
          end else begin
            pa_q   <= '0;
            addr_q <= {base_sel, req_va_i[ADDR_W-1 -: IDX_W], {ENT_B{1'b0}}};
            st_q   <= ST_SEG_REQ;
          end
        end
        ST_SEG_REQ: if (mem_rd_ready_i) st_q <= ST_SEG_WAIT;
        ST_SEG_WAIT: if (mem_rd_rvalid_i) begin
          if (seg_fault_i != FLT_NONE) begin
            flt_q <= seg_fault_i;
            st_q  <= ST_DONE;
          end else begin
            addr_q <= {seg_frame_i, va_q[OFF_W +: IDX_W], {ENT_B{1'b0}}};
            st_q   <= ST_PG_REQ;
          end
        end
        ST_PG_REQ: if (mem_rd_ready_i) st_q <= ST_PG_WAIT;
        ST_PG_WAIT: if (mem_rd_rvalid_i) begin
          if (pg_fault_i != FLT_NONE) begin
            flt_q <= pg_fault_i;
            st_q  <= ST_DONE;
          end else begin
            pa_q <= {pg_frame_i, va_q[OFF_W-1:0]};
            ci_q <= pg_ci_i;
            wb_q <= pg_upd_i;
            st_q <= pg_wb_i ? ST_WB : ST_DONE;
          end
        end
        ST_WB:   if (mem_wr_ready_i) st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (st_q == ST_IDLE);
  assign mem_rd_valid_o = (st_q == ST_SEG_REQ) || (st_q == ST_PG_REQ);
  assign mem_rd_addr_o  = addr_q;
  assign mem_wr_valid_o = (st_q == ST_WB);
  assign mem_wr_addr_o  = addr_q;
  assign mem_wr_data_o  = wb_q;
  assign done_o         = (st_q == ST_DONE);
  assign pa_o           = pa_q;
  assign cache_inh_o    = ci_q;
  assign fault_o        = flt_q;
  assign write_o        = wr_q;

  p_rd_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o && !mem_rd_ready_i |=> mem_rd_valid_o && $stable(mem_rd_addr_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_one_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_valid_o && mem_wr_valid_o));
  p_wb_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> mem_wr_data_o[PG_REF_BIT] && mem_wr_data_o[PG_V_BIT]);
  p_wb_then_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && mem_wr_ready_i |=> done_o && fault_o == FLT_NONE);
  p_fault_pa_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o != FLT_NONE |-> pa_o == '0 && !cache_inh_o);
  p_prot_needs_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == FLT_PROT |-> write_o);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_va_i,
  input  logic        req_super_i,
  input  logic        req_write_i,
  input  logic [19:0] user_base_i,
  input  logic [19:0] super_base_i,
  input  logic        user_en_i,
  input  logic        super_en_i,
  output logic        mem_rd_valid_o,
  output logic [31:0] mem_rd_addr_o,
  input  logic        mem_rd_ready_i,
  input  logic        mem_rd_rvalid_i,
  input  logic [31:0] mem_rd_data_i,
  output logic        mem_wr_valid_o,
  output logic [31:0] mem_wr_addr_o,
  output logic [31:0] mem_wr_data_o,
  input  logic        mem_wr_ready_i,
  output logic        done_o,
  output logic [31:0] pa_o,
  output logic        cache_inh_o,
  output logic [1:0]  fault_o
);
  fault_e             seg_fault, pg_fault;
  logic [FRAME_W-1:0] seg_frame, pg_frame;
  logic               seg_ci, pg_ci, seg_wb, pg_wb, wr;
  logic [ADDR_W-1:0]  seg_upd, pg_upd;

  pt_entry_check #(.IS_LEAF(1'b0)) u_seg_chk (
    .entry_i(mem_rd_data_i), .write_i(wr), .fault_o(seg_fault),
    .frame_o(seg_frame), .ci_o(seg_ci), .upd_o(seg_upd), .wb_o(seg_wb)
  );

  pt_entry_check #(.IS_LEAF(1'b1)) u_pg_chk (
    .entry_i(mem_rd_data_i), .write_i(wr), .fault_o(pg_fault),
    .frame_o(pg_frame), .ci_o(pg_ci), .upd_o(pg_upd), .wb_o(pg_wb)
  );

  pt_walk_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_va_i(req_va_i), .req_super_i(req_super_i), .req_write_i(req_write_i),
    .user_base_i(user_base_i), .super_base_i(super_base_i),
    .user_en_i(user_en_i), .super_en_i(super_en_i),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_ready_i(mem_rd_ready_i), .mem_rd_rvalid_i(mem_rd_rvalid_i),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_addr_o(mem_wr_addr_o),
    .mem_wr_data_o(mem_wr_data_o), .mem_wr_ready_i(mem_wr_ready_i),
    .done_o(done_o), .pa_o(pa_o), .cache_inh_o(cache_inh_o), .fault_o(fault_o),
    .write_o(wr),
    .seg_fault_i(seg_fault), .seg_frame_i(seg_frame),
    .pg_fault_i(pg_fault), .pg_frame_i(pg_frame), .pg_ci_i(pg_ci),
    .pg_upd_i(pg_upd), .pg_wb_i(pg_wb)
  );

  // Unused outputs of the top-level checker instance.
  logic unused_seg;
  assign unused_seg = seg_ci ^ seg_wb ^ (^seg_upd);

  p_seg_fault_codes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_rvalid_i && seg_fault == FLT_TABLE |-> !mem_rd_data_i[SEG_V_BIT]);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] SUP_BASE = 20'd0;
  localparam logic [19:0] USR_BASE = 20'd1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_super = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        user_en = 1'b1, super_en = 1'b1;
  logic        rd_valid, rd_ready = 1'b0, rvalid = 1'b0;
  logic [31:0] rd_addr, rdata = '0;
  logic        wr_valid;
  logic [31:0] wr_addr, wr_data;
  logic        done;
  logic [31:0] pa;
  logic        ci;
  logic [1:0]  flt;

  logic [31:0] mem [4096];
  logic        tb_we = 1'b0;
  logic [11:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] last_rd_addr = '0;
  int          checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_super_i(req_super), .req_write_i(req_write),
    .user_base_i(USR_BASE), .super_base_i(SUP_BASE),
    .user_en_i(user_en), .super_en_i(super_en),
    .mem_rd_valid_o(rd_valid), .mem_rd_addr_o(rd_addr), .mem_rd_ready_i(rd_ready),
    .mem_rd_rvalid_i(rvalid), .mem_rd_data_i(rdata),
    .mem_wr_valid_o(wr_valid), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .mem_wr_ready_i(1'b1),
    .done_o(done), .pa_o(pa), .cache_inh_o(ci), .fault_o(flt)
  );

  always @(negedge clk) rd_ready <= ~rd_ready;

  always @(posedge clk) begin
    rvalid <= 1'b0;
    if (rd_valid && rd_ready) begin
      rdata        <= mem[rd_addr[13:2]];
      rvalid       <= 1'b1;
      last_rd_addr <= rd_addr;
      n_rd         <= n_rd + 1;
    end
    if (wr_valid) begin
      mem[wr_addr[13:2]] <= wr_data;
      n_wr <= n_wr + 1;
    end
    if (tb_we) mem[tb_wa] <= tb_wd;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // Issues one request; returns cycles from acceptance to done.
  task automatic walk(input logic [31:0] va, input bit sup, input bit wr, output int cyc);
    @(negedge clk);
    req_va = va; req_super = sup; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      chk(!req_ready, "R10 ready while busy", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", {31'b0, req_ready}, 32'd1);
    chk(done == 1'b0, "R10 reset done", {31'b0, done}, 32'd0);
    chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R10 reset mem idle", {31'b0, rd_valid}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < 512; k++) begin
      bit sup, wr, sv, sro, pv, pro, pref, pmod, pci;
      logic [31:0] va, ste, pte, npte, epa, ste_a, pte_a;
      logic [19:0] sfr, pfr;
      logic [1:0] ef;
      int er, ew, r0, w0;
      {sup, wr, sv, sro, pv, pro, pref, pmod, pci} = k[8:0];
      va  = {k[9:0] ^ 10'h2a5, 10'd1023 - k[9:0], k[11:0] ^ 12'hc3c};
      sfr = sup ? 20'd2 : 20'd3;
      pfr = 20'h8a000 + 20'(k * 7);
      ste = {sfr, 8'h00, 1'b1, sro, sv, 1'b0};
      pte = {pfr, 5'h00, pci, 1'b0, pmod, pref, pro, 1'b0, pv};
      ste_a = {sup ? SUP_BASE : USR_BASE, va[31:22], 2'b00};
      pte_a = {sfr, va[21:12], 2'b00};
      poke(ste_a[13:2], ste);
      poke(pte_a[13:2], pte);
      ef = 2'b00; er = 2; ew = 0; epa = 32'd0; npte = pte;
      if (!sv)              begin ef = 2'b01; er = 1; end
      else if (sro && wr)   begin ef = 2'b11; er = 1; end
      else if (!pv)         ef = 2'b10;
      else if (pro && wr)   ef = 2'b11;
      else begin
        epa  = {pfr, va[11:0]};
        npte = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
        ew   = (npte != pte) ? 1 : 0;
      end
      r0 = n_rd; w0 = n_wr;
      walk(va, sup, wr, cyc);
      chk(done, "R10 done seen", {31'b0, done}, 32'd1);
      case (ef)
        2'b01:   chk(flt == ef, "R3 table fault", {30'b0, flt}, {30'b0, ef});
        2'b10:   chk(flt == ef, "R5 page fault", {30'b0, flt}, {30'b0, ef});
        2'b11:   chk(flt == ef, (er == 1) ? "R4 seg prot" : "R6 page prot", {30'b0, flt}, {30'b0, ef});
        default: chk(flt == ef, "R7 no fault", {30'b0, flt}, {30'b0, ef});
      endcase
      chk(pa == epa, (ef == 0) ? "R7 pa" : "R9 pa zero on fault", pa, epa);
      chk(ci == ((ef == 0) ? pci : 1'b0), "R7 cache inhibit", {31'b0, ci}, {31'b0, (ef == 0) ? pci : 1'b0});
      chk(n_rd - r0 == er, (er == 1) ? "R3 R4 single read" : "R2 two reads", 32'(n_rd - r0), 32'(er));
      if (er == 2) chk(last_rd_addr == pte_a, "R2 leaf addr", last_rd_addr, pte_a);
      else         chk(last_rd_addr == ste_a, "R1 top addr", last_rd_addr, ste_a);
      chk(n_wr - w0 == ew, "R8 write count", 32'(n_wr - w0), 32'(ew));
      chk(mem[pte_a[13:2]] == npte, "R8 leaf word", mem[pte_a[13:2]], npte);
      @(negedge clk);
      chk(!done, "R10 done pulse", {31'b0, done}, 32'd0);
    end

    // Pass-through per mode.
    for (int m = 0; m < 4; m++) begin
      logic [31:0] va;
      int r0;
      va = 32'hdead_b000 ^ 32'(m * 32'h1357);
      super_en = (m == 1) ? 1'b0 : 1'b1;
      user_en  = (m == 2) ? 1'b0 : 1'b1;
      if (m == 1 || m == 2) begin
        r0 = n_rd;
        walk(va, m == 1, m[0], cyc);
        chk(cyc == 1 && done, "R9 bypass latency", 32'(cyc), 32'd1);
        chk(pa == va, "R9 bypass pa", pa, va);
        chk(flt == 2'b00, "R9 bypass fault", {30'b0, flt}, 32'd0);
        chk(n_rd == r0, "R9 bypass no reads", 32'(n_rd - r0), 32'd0);
      end
    end
    super_en = 1'b1; user_en = 1'b1;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule